// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker turns a 32-bit virtual address into a 36-bit physical address by reading a three-level translation table out of memory. A client hands it a virtual address together with the base of the top-level table. The walker then reads one 32-bit table entry per level over a simple read port with a request/response handshake. Each read depends on the entry returned before it. It finishes by returning either the translated address or a fault that names the level whose entry was not valid.

The virtual address is split unevenly. Two bits select one of four entries in a small top-level table. Two 9-bit fields select entries in the middle-level and bottom-level tables, and each of those tables is 2 KB. The low 12 bits pass through untouched as the offset within a 4 KB page. Intermediate entries carry a 25-bit table pointer, so a 2 KB table can sit anywhere in the 36-bit space. Bottom-level entries carry a 24-bit frame number. Only one translation is in flight at a time.

Top module: `xlate_walker`

## Requirements
- R1: The first read goes to address {root[35:4], 4'b0000} + 4 * vaddr[31:30]; the low four bits of the root input are ignored.
- R2: The second read goes to ({E1[31:7]} << 11) + 4 * vaddr[29:21], where E1 is the first entry returned.
- R3: The third read goes to ({E2[31:7]} << 11) + 4 * vaddr[20:12], where E2 is the second entry returned.
- R4: If all three entries are valid, the response has paddr = {E3[31:8], vaddr[11:0]}, fault = 0 and level = 0.
- R5: Bit 0 of every entry is its valid flag. A clear flag ends the walk at once, with no further reads, and gives fault = 1, paddr = 0 and level = 1, 2 or 3 for the first, second or third read.
- R6: A memory read request keeps its valid and address unchanged until mem_req_ready_i is seen high. Exactly one response is consumed per request, and it is taken only after that request has been accepted.
- R7: A response keeps its valid and fields unchanged until rsp_ready_i is seen high. req_ready_o stays low from the accepted request until its response is taken, so a new request raised in the same cycle as the take is accepted no earlier than the next cycle.
- R8: After reset, req_ready_o is 1 and mem_req_valid_o and rsp_valid_o are 0.
- R9: Entry bits 6:1, and bit 7 of bottom-level entries, have no effect on read addresses or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_root_i | input | 36 | Top-level table base (16-byte aligned) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 36 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data returned |
| mem_rsp_data_i | input | 32 | Entry contents |
| rsp_valid_o | output | 1 | Translation result present |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_paddr_o | output | 36 | Translated physical address |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_level_o | output | 2 | Level of the faulting entry, 0 on success |

## Verification
Two functions can fall into the same cycle. One is the consumer taking a finished result. The other is a client offering the next translation, which must not be accepted until the walker is idle again. The bench raises rsp_ready_i and a new req_valid_i on the same edge. It checks that req_ready_o is low in that cycle and high in the following one, and that the second translation then completes with its own correct address. Memory-side stalls are also inserted while a read request is pending, and the bench checks that the address stays stable across them.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  parameter int unsigned VA_W     = 32;
  parameter int unsigned PA_W     = 36;
  parameter int unsigned OFF_W    = 12;
  parameter int unsigned TOP_IDX_W = 2;
  parameter int unsigned SUB_IDX_W = 9;
  parameter int unsigned PTE_W    = 32;
  parameter int unsigned PTE_LOG  = 2;

  localparam int unsigned SUB_TBL_LOG = SUB_IDX_W + PTE_LOG;  // 2 KB tables
  localparam int unsigned PTR_W       = PA_W - SUB_TBL_LOG;   // 25
  localparam int unsigned PFN_W       = PA_W - OFF_W;         // 24
  localparam int unsigned ROOT_LOG    = TOP_IDX_W + PTE_LOG;  // 16 B alignment

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } walk_st_e;

  typedef logic [1:0] lvl_t;
endpackage

// File: rtl/xlate_va_split.sv
module xlate_va_split
  import xlate_pkg::*;
#(
  parameter int unsigned VW   = VA_W,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned TW   = TOP_IDX_W,
  parameter int unsigned SW   = SUB_IDX_W
) (
  input  logic [VW-1:0] vaddr_i,
  input  lvl_t          lvl_i,
  output logic [SW-1:0] idx_o,
  output logic [OW-1:0] off_o
);
  localparam int unsigned L2_LO = OW + SW;

  logic [TW-1:0] top_idx;
  logic [SW-1:0] mid_idx;
  logic [SW-1:0] bot_idx;

  assign top_idx = vaddr_i[VW-1 -: TW];
  assign mid_idx = vaddr_i[L2_LO +: SW];
  assign bot_idx = vaddr_i[OW +: SW];
  assign off_o   = vaddr_i[OW-1:0];

  always_comb begin
    unique case (lvl_i)
      2'd1:    idx_o = {{(SW-TW){1'b0}}, top_idx};
      2'd2:    idx_o = mid_idx;
      default: idx_o = bot_idx;
    endcase
  end
endmodule

// File: rtl/xlate_pte_addr.sv
module xlate_pte_addr
  import xlate_pkg::*;
#(
  parameter int unsigned AW = PA_W,
  parameter int unsigned IW = SUB_IDX_W,
  parameter int unsigned SH = PTE_LOG
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] scaled;
  assign scaled = {{(AW-IW-SH){1'b0}}, idx_i, {SH{1'b0}}};
  assign addr_o = base_i + scaled;
endmodule

// File: rtl/xlate_pte_decode.sv
module xlate_pte_decode
  import xlate_pkg::*;
#(
  parameter int unsigned EW  = PTE_W,
  parameter int unsigned AW  = PA_W,
  parameter int unsigned PW  = PTR_W,
  parameter int unsigned FW  = PFN_W
) (
  input  logic [EW-1:0] pte_i,
  output logic          valid_o,
  output logic [AW-1:0] next_base_o,
  output logic [FW-1:0] pfn_o
);
  logic [EW-FW-2:0] unused_pte_bits;

  assign valid_o         = pte_i[0];
  assign next_base_o     = {pte_i[EW-1 -: PW], {(AW-PW){1'b0}}};
  assign pfn_o           = pte_i[EW-1 -: FW];
  assign unused_pte_bits = pte_i[EW-FW-1:1];
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PA_W-1:0]  req_root_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output lvl_t             rsp_level_o
);
  localparam lvl_t LAST_LVL = 2'd3;

  walk_st_e         state_q;
  lvl_t             lvl_q;
  lvl_t             flvl_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;

  logic [SUB_IDX_W-1:0] idx;
  logic [OFF_W-1:0]     off;
  logic                 pte_valid;
  logic [PA_W-1:0]      next_base;
  logic [PFN_W-1:0]     pfn;
  logic [ROOT_LOG-1:0]  unused_root_lo;
  logic                 accept;

  assign unused_root_lo = req_root_i[ROOT_LOG-1:0];

  xlate_va_split u_split (
    .vaddr_i (va_q),
    .lvl_i   (lvl_q),
    .idx_o   (idx),
    .off_o   (off)
  );

  xlate_pte_addr u_addr (
    .base_i  (base_q),
    .idx_i   (idx),
    .addr_o  (mem_req_addr_o)
  );

  xlate_pte_decode u_dec (
    .pte_i       (mem_rsp_data_i),
    .valid_o     (pte_valid),
    .next_base_o (next_base),
    .pfn_o       (pfn)
  );

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign rsp_paddr_o     = paddr_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = flvl_q;
  assign accept          = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= 2'd1;
      flvl_q  <= 2'd0;
      va_q    <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_vaddr_i;
          base_q  <= {req_root_i[PA_W-1:ROOT_LOG], {ROOT_LOG{1'b0}}};
          lvl_q   <= 2'd1;
          state_q <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!pte_valid) begin
            fault_q <= 1'b1;
            flvl_q  <= lvl_q;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end else if (lvl_q == LAST_LVL) begin
            fault_q <= 1'b0;
            flvl_q  <= 2'd0;
            paddr_q <= {pfn, off};
            state_q <= ST_DONE;
          end else begin
            base_q  <= next_base;
            lvl_q   <= lvl_q + 2'd1;
            state_q <= ST_REQ;
          end
        end
        ST_DONE: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk
  import xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PA_W-1:0]  req_root_i,
  input  logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  input  logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  input  logic [PA_W-1:0]  rsp_paddr_o,
  input  logic             rsp_fault_o,
  input  lvl_t             rsp_level_o
);
  logic [VA_W-1:0] va_cap;
  logic [PA_W-1:0] root_cap;
  logic            first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_cap   <= '0;
      root_cap <= '0;
      first_q  <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      va_cap   <= req_vaddr_i;
      root_cap <= req_root_i;
      first_q  <= 1'b1;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      first_q  <= 1'b0;
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !rsp_valid_o);

  assert_root_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q && mem_req_valid_o |->
      mem_req_addr_o[PA_W-1:ROOT_LOG] == root_cap[PA_W-1:ROOT_LOG]);

  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |->
      rsp_paddr_o[OFF_W-1:0] == va_cap[OFF_W-1:0] && rsp_level_o == 2'd0);

  assert_fault_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_level_o != 2'd0 && rsp_paddr_o == '0);

  assert_mem_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_rsp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=>
      rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_level_o));

  assert_single_walk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o && !mem_req_valid_o);
endmodule

bind xlate_walker xlate_walker_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .req_root_i      (req_root_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_level_o     (rsp_level_o)
);

// File: tb/xlate_walker_test.sv
`timescale 1ns/1ps
module xlate_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [35:0] req_root_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [35:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [35:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic [1:0]  rsp_level_o;

  int checks = 0;
  int errors = 0;
  int mem_stall = 0;
  int mem_lat = 0;
  int rd_cnt = 0;
  logic [35:0] rd_addr [0:7];
  logic [31:0] mem_q [logic [35:0]];

  always #4 clk_i = ~clk_i;

  xlate_walker uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: optional stall before accept, optional latency before data
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_req_valid_o) begin
        logic [35:0] a;
        a = mem_req_addr_o;
        for (int s = 0; s < mem_stall; s++) begin
          @(negedge clk_i);
          check(mem_req_valid_o && mem_req_addr_o == a, "R6", "held request",
                {27'd0, mem_req_valid_o, mem_req_addr_o}, {27'd0, 1'b1, a});
        end
        mem_req_ready_i = 1'b1;
        if (rd_cnt < 8) rd_addr[rd_cnt] = a;
        rd_cnt++;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        for (int l = 0; l < mem_lat; l++) @(negedge clk_i);
        mem_rsp_data_i  = mem_q.exists(a) ? mem_q[a] : 32'h0;
        mem_rsp_valid_i = 1'b1;
        @(negedge clk_i);
        mem_rsp_valid_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [35:0] a1(input logic [31:0] va, input logic [35:0] root);
    return {root[35:4], 4'b0} + {32'd0, va[31:30], 2'b00};
  endfunction
  function automatic logic [35:0] a2(input logic [31:0] va, input logic [24:0] p);
    return {p, 11'd0} + {25'd0, va[29:21], 2'b00};
  endfunction
  function automatic logic [35:0] a3(input logic [31:0] va, input logic [24:0] p);
    return {p, 11'd0} + {25'd0, va[20:12], 2'b00};
  endfunction

  // bad_lvl: 0 = all valid, else level whose entry is invalid; bits 7:1 get junk (R9)
  task automatic build(input logic [31:0] va, input logic [35:0] root,
                       input logic [24:0] p2, input logic [24:0] p3,
                       input logic [23:0] pfn, input int bad_lvl);
    mem_q[a1(va, root)] = {p2, 6'b101101, bad_lvl != 1};
    mem_q[a2(va, p2)]   = {p3, 6'b010110, bad_lvl != 2};
    mem_q[a3(va, p3)]   = {pfn, 7'b1101011, bad_lvl != 3};
  endtask

  task automatic start_req(input logic [31:0] va, input logic [35:0] root);
    @(negedge clk_i);
    req_vaddr_i = va;
    req_root_i  = root;
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_rsp(input string req);
    int n = 0;
    while (!rsp_valid_o && n < 400) begin
      @(negedge clk_i);
      n++;
    end
    check(rsp_valid_o, req, "response timeout", {63'd0, rsp_valid_o}, 64'd1);
  endtask

  task automatic take_rsp();
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  task automatic walk_ok(input string tag, input logic [31:0] va, input logic [35:0] root,
                         input logic [24:0] p2, input logic [24:0] p3, input logic [23:0] pfn);
    build(va, root, p2, p3, pfn, 0);
    rd_cnt = 0;
    start_req(va, root);
    wait_rsp(tag);
    check(rd_cnt == 3, "R4", {tag, " read count"}, 64'(rd_cnt), 64'd3);
    check(rd_addr[0] == a1(va, root), "R1", {tag, " first addr"},
          {28'd0, rd_addr[0]}, {28'd0, a1(va, root)});
    check(rd_addr[1] == a2(va, p2), "R2", {tag, " second addr"},
          {28'd0, rd_addr[1]}, {28'd0, a2(va, p2)});
    check(rd_addr[2] == a3(va, p3), "R3", {tag, " third addr"},
          {28'd0, rd_addr[2]}, {28'd0, a3(va, p3)});
    check(rsp_paddr_o == {pfn, va[11:0]} && !rsp_fault_o && rsp_level_o == 2'd0,
          "R4", {tag, " result"}, {25'd0, rsp_fault_o, rsp_level_o, rsp_paddr_o},
          {28'd0, pfn, va[11:0]});
    take_rsp();
  endtask

  task automatic walk_fault(input int lvl);
    logic [31:0] va;
    logic [35:0] root;
    va   = 32'h4000_0000 * lvl + 32'h0015_3abc;
    root = 36'h1_2000_0000 + 36'h100 * lvl;
    build(va, root, 25'h0a000 + 25'(lvl), 25'h0b000 + 25'(lvl), 24'h55aa00, lvl);
    rd_cnt = 0;
    start_req(va, root);
    wait_rsp("R5");
    check(rsp_fault_o && rsp_level_o == 2'(lvl) && rsp_paddr_o == '0, "R5", "fault result",
          {25'd0, rsp_fault_o, rsp_level_o, rsp_paddr_o}, {25'd0, 1'b1, 2'(lvl), 36'd0});
    check(rd_cnt == lvl, "R5", "reads before fault", 64'(rd_cnt), 64'(lvl));
    take_rsp();
  endtask

  task automatic test_reset();
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R8", "reset state",
          {61'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 64'd4);
  endtask

  task automatic test_basic();
    mem_stall = 0; mem_lat = 0;
    walk_ok("basic", 32'hC1F3_5123, 36'h8_7654_3210, 25'h1abcde, 25'h0f0f0f, 24'hfedcba);
    walk_ok("zero", 32'h0000_0000, 36'h0_0000_0040, 25'h000001, 25'h000002, 24'h000003);
  endtask

  task automatic test_stalls();
    mem_stall = 3; mem_lat = 2;
    walk_ok("stall", 32'h7FFF_FFFF, 36'h3_0000_0000, 25'h1fffff, 25'h155555, 24'h123456);
    mem_stall = 0; mem_lat = 0;
  endtask

  task automatic test_root_low_bits();
    // root low four bits nonzero, ignored by R1
    walk_ok("R1 root", 32'h8020_1fff, 36'h5_0000_100F, 25'h0c0000, 25'h0d0000, 24'h00abcd);
  endtask

  task automatic test_backpressure();
    logic [35:0] pa;
    build(32'h4ABC_D0E0, 36'h6_0000_0000, 25'h011111, 25'h022222, 24'h333333, 0);
    start_req(32'h4ABC_D0E0, 36'h6_0000_0000);
    wait_rsp("R7");
    pa = rsp_paddr_o;
    req_vaddr_i = 32'h0; req_root_i = 36'h6_0000_0000; req_valid_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check(rsp_valid_o && rsp_paddr_o == pa && !req_ready_o && !mem_req_valid_o, "R7",
            "held response", {27'd0, rsp_valid_o, rsp_paddr_o}, {27'd0, 1'b1, pa});
    end
    req_valid_i = 1'b0;
    take_rsp();
  endtask

  task automatic test_same_cycle();
    logic [31:0] vb;
    vb = 32'hB0C0_5678;
    build(32'h1234_5678, 36'h7_0000_0000, 25'h044444, 25'h055555, 24'h666666, 0);
    build(vb, 36'h7_1000_0000, 25'h077777, 25'h088888, 24'h999999, 0);
    start_req(32'h1234_5678, 36'h7_0000_0000);
    wait_rsp("R7");
    req_vaddr_i = vb; req_root_i = 36'h7_1000_0000;
    req_valid_i = 1'b1; rsp_ready_i = 1'b1;
    check(!req_ready_o, "R7", "ready low with take", {63'd0, req_ready_o}, 64'd0);
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R7", "idle cycle after take",
          {61'd0, req_ready_o, rsp_valid_o, mem_req_valid_o}, 64'd4);
    rd_cnt = 0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(!req_ready_o, "R7", "accepted next cycle", {63'd0, req_ready_o}, 64'd0);
    wait_rsp("R7");
    check(rsp_paddr_o == {24'h999999, vb[11:0]} && !rsp_fault_o, "R7", "second result",
          {27'd0, rsp_fault_o, rsp_paddr_o}, {28'd0, 24'h999999, vb[11:0]});
    take_rsp();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_basic();
    test_stalls();
    test_root_low_bits();
    walk_fault(1);
    walk_fault(2);
    walk_fault(3);
    test_backpressure();
    test_same_cycle();
    repeat (4) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule